// File: doc/BRIEF.md
# Waveform Sample Selector and Rate Decimator

This block picks one stream out of a bank of parallel sample buses and republishes it at a slower, programmable rate. Each of three phases carries five products: current, voltage, active power, reactive power and apparent power. An 8-bit mode byte chooses the phase, the product and the output rate. The chosen stream is captured into an output register once per output period, and a one-clock valid strobe marks each capture.

The output rate comes from the block clock. A fixed prescaler divides it by three. A decimation counter then divides the result by 128, 256, 512 or 1024. When the mode byte holds a reserved phase or product code, the block emits no strobes and holds its output at zero. The top bit of the mode byte is passed out as a select line. A pulse-frequency generator elsewhere uses it to choose between reactive power and apparent power.

A write that changes the rate code restarts both counters. The first strobe after such a write therefore arrives one full period of the new rate later. A write that keeps the rate code leaves the counters running.

Top module: `wave_pick`

## Requirements
- R1: Mode bits [1:0] pick the phase. 00 selects lane 0 (A), 01 selects lane 1 (B) and 10 selects lane 2 (C) of each bus. Lane n occupies bits [n*SAMPLE_W +: SAMPLE_W].
- R2: Mode bits [4:2] pick the product. 000 selects current, 001 voltage, 010 active power, 011 reactive power and 100 apparent power.
- R3: Mode bits [6:5] set the output period to 3*128, 3*256, 3*512 or 3*1024 clocks for codes 00, 01, 10 and 11. After reset with no rate change, the first strobe is high in the cycle after the 3*N-th rising edge.
- R4: sampleValid is high for exactly one clock per output period.
- R5: sampleOut is the value of the selected stream, captured on the edge that raises sampleValid. It holds that value until the next capture.
- R6: A phase code of 11 or a product code of 101, 110 or 111 suppresses sampleValid. From the cycle after that mode is written, sampleOut is 0.
- R7: pulseSelApp follows mode bit 7: 1 selects apparent power and 0 selects reactive power.
- R8: Reset clears the mode byte to zero and clears sampleOut, sampleValid and pulseSelApp to 0.
- R9: A mode write that changes bits [6:5] restarts the prescaler and the decimation counter. The next strobe then comes 3*N clocks after the write edge. A write that keeps the rate code leaves the counters running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| modeWr | input | 1 | Loads modeIn into the mode byte |
| modeIn | input | 8 | Mode byte: [1:0] phase, [4:2] product, [6:5] rate, [7] pulse select |
| curIn | input | 3*SAMPLE_W | Current samples, one lane per phase |
| voltIn | input | 3*SAMPLE_W | Voltage samples, one lane per phase |
| actIn | input | 3*SAMPLE_W | Active-power products, one lane per phase |
| reactIn | input | 3*SAMPLE_W | Reactive-power products, one lane per phase |
| appIn | input | 3*SAMPLE_W | Apparent-power products, one lane per phase |
| sampleOut | output | SAMPLE_W | Captured sample |
| sampleValid | output | 1 | One-clock strobe per output period |
| pulseSelApp | output | 1 | Pulse-output source select: 1 for apparent power, 0 for reactive power |

## Verification
Every lane of every bus carries a value that encodes its product, its phase and a per-run seed. A wrong lane or a wrong bus therefore shows up as a distinct miscompare. The vector table covers all five products, all three phases, all four rates and both pulse-select values. It also includes reserved phase and product codes, which separate a correct mux from one that leaks a neighbouring lane or still strobes. The streams change right after each capture, which separates a held output from one that follows its input. Directed runs cover reset, a mid-period rate change against a same-rate rewrite, and a switch to a reserved code while running.

// File: rtl/wave_pick_pkg.sv
`timescale 1ns/1ps
package wave_pick_pkg;
  localparam int NUM_PHASE = 3;
  localparam int NUM_KIND  = 5;
  localparam logic [1:0] PHASE_RSV = 2'b11;
  localparam logic [2:0] KIND_MAX  = 3'd4;

  // mode byte layout, bit 7 down to bit 0
  typedef struct packed {
    logic       pulseApp;
    logic [1:0] rate;
    logic [2:0] kind;
    logic [1:0] phase;
  } modeByte_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       fire;
    logic       legal;
    logic [1:0] phase;
    logic [2:0] kind;
  } tapCtl_t;
endpackage

// File: rtl/wave_pick_ctrl.sv
`timescale 1ns/1ps
module wave_pick_ctrl
  import wave_pick_pkg::*;
#(
  parameter int PRE_DIV  = 3,
  parameter int BASE_DIV = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWr,
  input  logic [7:0] modeIn,
  output tapCtl_t    ctl,
  output logic       pulseSelApp
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int DEC_W = $clog2(BASE_DIV * 8);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [DEC_W-1:0] BASE_L   = DEC_W'(BASE_DIV);

  modeByte_t         modeReg;
  modeByte_t         modeNew;
  logic [PRE_W-1:0]  preCnt;
  logic [DEC_W-1:0]  decCnt;
  logic [DEC_W-1:0]  decLast;
  logic              preTick;
  logic              restart;
  logic              phaseOk;
  logic              kindOk;

  assign modeNew = modeByte_t'(modeIn);

  always_ff @(posedge clk) begin
    if (!rstN)       modeReg <= '0;
    else if (modeWr) modeReg <= modeNew;
  end

  assign restart = modeWr && (modeNew.rate != modeReg.rate);
  assign decLast = (BASE_L << modeReg.rate) - 1'b1;
  assign preTick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      preCnt <= '0;
      decCnt <= '0;
    end else if (preTick) begin
      preCnt <= '0;
      decCnt <= (decCnt == decLast) ? '0 : decCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign phaseOk = (modeReg.phase != PHASE_RSV);
  assign kindOk  = (modeReg.kind <= KIND_MAX);

  always_comb begin
    ctl.fire  = preTick && (decCnt == decLast) && !restart;
    ctl.legal = phaseOk && kindOk;
    ctl.phase = modeReg.phase;
    ctl.kind  = modeReg.kind;
  end

  assign pulseSelApp = modeReg.pulseApp;

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= PRE_LAST);

  // R3
  dec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    decCnt <= decLast);

  // R9
  rate_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (preCnt == '0 && decCnt == '0));
endmodule

// File: rtl/wave_pick_dp.sv
`timescale 1ns/1ps
module wave_pick_dp
  import wave_pick_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tapCtl_t                       ctl,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] curIn,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] voltIn,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] actIn,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] reactIn,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] appIn,
  output logic [SAMPLE_W-1:0]           sampleOut,
  output logic                          sampleValid
);
  localparam int BUS_W = NUM_PHASE * SAMPLE_W;

  logic [BUS_W-1:0]    busByKind [NUM_KIND];
  logic [SAMPLE_W-1:0] lanes     [NUM_KIND][4];
  logic [SAMPLE_W-1:0] pick;

  assign busByKind[0] = curIn;
  assign busByKind[1] = voltIn;
  assign busByKind[2] = actIn;
  assign busByKind[3] = reactIn;
  assign busByKind[4] = appIn;

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    for (genvar p = 0; p < 4; p++) begin : g_phase
      if (p < NUM_PHASE) begin : g_live
        assign lanes[k][p] = busByKind[k][p*SAMPLE_W +: SAMPLE_W];
      end else begin : g_pad
        assign lanes[k][p] = '0;
      end
    end
  end

  always_comb begin
    pick = '0;
    if (ctl.kind <= KIND_MAX) pick = lanes[ctl.kind][ctl.phase];
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.legal) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else if (ctl.fire) begin
      sampleOut   <= pick;
      sampleValid <= 1'b1;
    end else begin
      sampleValid <= 1'b0;
    end
  end

  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R4
  valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(ctl.fire));

  // R5
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.legal && !ctl.fire) |=> $stable(sampleOut));

  // R6
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.legal |=> (!sampleValid && sampleOut == '0));
endmodule

// File: rtl/wave_pick.sv
`timescale 1ns/1ps
module wave_pick
  import wave_pick_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int PRE_DIV  = 3,
  parameter int BASE_DIV = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          modeWr,
  input  logic [7:0]                    modeIn,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] curIn,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] voltIn,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] actIn,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] reactIn,
  input  logic [NUM_PHASE*SAMPLE_W-1:0] appIn,
  output logic [SAMPLE_W-1:0]           sampleOut,
  output logic                          sampleValid,
  output logic                          pulseSelApp
);
  tapCtl_t ctl;

  wave_pick_ctrl #(
    .PRE_DIV (PRE_DIV),
    .BASE_DIV(BASE_DIV)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeWr     (modeWr),
    .modeIn     (modeIn),
    .ctl        (ctl),
    .pulseSelApp(pulseSelApp)
  );

  wave_pick_dp #(
    .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .curIn      (curIn),
    .voltIn     (voltIn),
    .actIn      (actIn),
    .reactIn    (reactIn),
    .appIn      (appIn),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );
endmodule

// File: tb/tb_wave_pick.sv
`timescale 1ns/1ps
module tb_wave_pick;
  localparam int W  = 24;
  localparam int NV = 12;
  // mode byte: {pulse, rate[1:0], kind[2:0], phase[1:0]}
  localparam logic [7:0] VEC [NV] = '{
    8'b0_00_000_00, 8'b1_01_001_01, 8'b0_00_010_10, 8'b0_10_011_00,
    8'b1_00_100_01, 8'b0_11_000_10, 8'b0_00_001_00, 8'b0_01_100_10,
    8'b0_00_000_11, 8'b1_00_101_00, 8'b0_01_111_01, 8'b0_00_011_10
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWr = 1'b0;
  logic [7:0] modeIn = '0;
  logic [3*W-1:0] curIn, voltIn, actIn, reactIn, appIn;
  logic [W-1:0] sampleOut;
  logic sampleValid, pulseSelApp;

  int nChecks = 0;
  int nFail = 0;
  int edgeCnt = 0;

  always #5 clk = ~clk;

  wave_pick dut (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeIn(modeIn),
    .curIn(curIn), .voltIn(voltIn), .actIn(actIn), .reactIn(reactIn),
    .appIn(appIn), .sampleOut(sampleOut), .sampleValid(sampleValid),
    .pulseSelApp(pulseSelApp)
  );

  function automatic logic [W-1:0] sv(input int k, input int p, input logic [7:0] s);
    return {s, 4'(k), 4'(p), s ^ 8'h5A};
  endfunction

  task automatic setStreams(input logic [7:0] s);
    for (int p = 0; p < 3; p++) begin
      curIn[p*W +: W]   = sv(0, p, s);
      voltIn[p*W +: W]  = sv(1, p, s);
      actIn[p*W +: W]   = sv(2, p, s);
      reactIn[p*W +: W] = sv(3, p, s);
      appIn[p*W +: W]   = sv(4, p, s);
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    edgeCnt++;
    @(negedge clk);
  endtask

  task automatic waitTo(input int n);
    while (edgeCnt < n) step();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    edgeCnt = 0;
  endtask

  task automatic writeMode(input logic [7:0] m);
    modeIn = m;
    modeWr = 1'b1;
    step();
    modeWr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    setStreams(8'h11);
    @(negedge clk);
    // R8: reset state
    doReset();
    check("R8 out", 32'(sampleOut), 0);
    check("R8 valid", 32'(sampleValid), 0);
    check("R8 pulse", 32'(pulseSelApp), 0);
    writeMode(8'h80);
    check("R7 pulse set", 32'(pulseSelApp), 1);
    doReset();
    check("R8 pulse cleared", 32'(pulseSelApp), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0] m;
      logic [7:0] sA, sB;
      int ph, kd, rt, n, fireEdge;
      bit legal, seen;
      m = VEC[v];
      ph = int'(m[1:0]); kd = int'(m[4:2]); rt = int'(m[6:5]);
      legal = (ph != 3) && (kd <= 4);
      n = 3 * (128 << rt);
      sA = 8'(8'h20 + v); sB = 8'(8'hC0 + v);
      doReset();
      setStreams(sA);
      writeMode(m);
      check("R7 pulse", 32'(pulseSelApp), 32'(m[7]));
      fireEdge = (rt != 0) ? 1 + n : n;
      if (legal) begin
        waitTo(fireEdge - 1);
        check("R3 early", 32'(sampleValid), 0);
        step();
        check("R3 first strobe", 32'(sampleValid), 1);
        check("R1 R2 sample", 32'(sampleOut), 32'(sv(kd, ph, sA)));
        setStreams(sB);
        step();
        check("R4 one wide", 32'(sampleValid), 0);
        check("R5 held", 32'(sampleOut), 32'(sv(kd, ph, sA)));
        waitTo(fireEdge + n - 1);
        check("R4 gap", 32'(sampleValid), 0);
        step();
        check("R3 period", 32'(sampleValid), 1);
        check("R5 new capture", 32'(sampleOut), 32'(sv(kd, ph, sB)));
      end else begin
        seen = 0;
        while (edgeCnt < fireEdge + 2) begin
          step();
          if (sampleValid || sampleOut != 0) seen = 1;
        end
        check("R6 reserved quiet", 32'(seen), 0);
      end
    end

    // R9: rate change restarts the period
    begin
      bit early;
      doReset();
      setStreams(8'h33);
      writeMode(8'h00);
      waitTo(100);
      writeMode(8'h20);
      early = 0;
      while (edgeCnt < 101 + 768 - 1) begin
        step();
        if (sampleValid) early = 1;
      end
      check("R9 no old-rate strobe", 32'(early), 0);
      step();
      check("R9 restart strobe", 32'(sampleValid), 1);
      check("R9 restart sample", 32'(sampleOut), 32'(sv(0, 0, 8'h33)));
    end

    // R9: same-rate rewrite keeps counting
    doReset();
    setStreams(8'h44);
    writeMode(8'h00);
    waitTo(200);
    writeMode(8'h01);
    waitTo(383);
    check("R9 same rate no early", 32'(sampleValid), 0);
    step();
    check("R9 same rate strobe", 32'(sampleValid), 1);
    check("R1 phase B lane", 32'(sampleOut), 32'(sv(0, 1, 8'h44)));

    // R6: switch to a reserved code while running
    writeMode(8'h03);
    check("R6 before clear", 32'(sampleOut), 32'(sv(0, 1, 8'h44)));
    step();
    check("R6 zero after reserved", 32'(sampleOut), 0);
    waitTo(edgeCnt + 400);
    check("R6 no strobe", 32'(sampleValid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule